// File: doc/BRIEF.md
# RAM Address Generator with Saved-Address Table

This block produces the address for a small coefficient and data RAM inside a pipelined signal-processing datapath. Each clock it takes a three-bit command and a six-bit table row index. The command can keep the address register, zero it, step it up or down, copy it into the modulus register, save it into a private table of addresses, or load it back from that table. The address register drives `addr_o` directly, so the RAM sees the result of a command from the clock edge that follows it.

Stepping wraps in one of two ways. A two-state controller tracks which way is in force. In state `WRAP_FULL` the modulus is zero and steps wrap across the whole address range. In state `WRAP_BOUNDED` the modulus M is non-zero and steps stay inside 0..M-1.

The controller changes state only on a set-modulus command:
- `WRAP_FULL -> WRAP_BOUNDED` when the address being copied is non-zero.
- `WRAP_BOUNDED -> WRAP_FULL` when the address being copied is zero.
- Every other command keeps the current state.

A sequencer uses the table to save and restore pointers into circular buffers, for example between the passes of a filter loop.

Top module: `ram_addr_unit`

## Requirements
- R1: While reset is low and after it is released, the address is 0, the modulus is 0 (full-range wrap) and every table row holds 0.
- R2: Command code 0 (hold) leaves the address unchanged.
- R3: Command code 1 (clear) sets the address to 0 on the next clock.
- R4: Command code 2 (step up) with modulus 0 adds one to the address, wrapping from 127 to 0.
- R5: Command code 3 (step down) with modulus 0 subtracts one from the address, wrapping from 0 to 127.
- R6: Command code 4 (set modulus) copies the current address into the modulus register and leaves the address unchanged.
- R7: With modulus M non-zero, step up gives 0 when the address is M-1 or higher, and gives address+1 otherwise.
- R8: With modulus M non-zero, step down gives M-1 when the address is 0 or is M or higher, and gives address-1 otherwise.
- R9: Command code 6 (save) writes the current address into the table row given by `row_i` and leaves the address unchanged.
- R10: Command code 5 (load) sets the address to the content of the table row given by `row_i`.
- R11: Command code 7 is reserved and changes neither the address nor the modulus.
- R12: A set-modulus command issued while the address is 0 returns stepping to full-range wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code, encoded as listed in the requirements |
| row_i | input | 6 | Table row used by the save and load commands |
| addr_o | output | 7 | Current RAM address register |

## Verification
Every cycle, the assertions check the single-step rules for each command:
- hold, clear and reserved leave the address as required;
- a step up or down gives the neighbouring address, including both wrap styles;
- set modulus copies the address into the modulus register.

Whether a loaded address equals the value saved earlier into the same row can only be shown by the bench scenarios, because that link spans an arbitrary number of cycles. The same applies to rows that were never written reading back zero, and to a modulus setting changing the wrap point of later steps. A long pseudo-random command mix, compared against an independent model, covers the interleavings of these effects.

// File: rtl/ram_addr_pkg.sv
`timescale 1ns/1ps
package ram_addr_pkg;
    localparam int ADDR_W  = 7;
    localparam int ROWS    = 64;
    localparam int ROW_W   = $clog2(ROWS);
    localparam int CMD_W   = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_HOLD   = 3'd0,
        CMD_CLEAR  = 3'd1,
        CMD_UP     = 3'd2,
        CMD_DOWN   = 3'd3,
        CMD_SETMOD = 3'd4,
        CMD_LOAD   = 3'd5,
        CMD_SAVE   = 3'd6,
        CMD_RSVD   = 3'd7
    } cmd_e;

    typedef enum logic {
        WRAP_FULL    = 1'b0,
        WRAP_BOUNDED = 1'b1
    } wrap_e;
endpackage

// File: rtl/ram_addr_table.sv
`timescale 1ns/1ps
module ram_addr_table #(
    parameter int ADDR_W = 7,
    parameter int ROWS   = 64,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    output logic [ADDR_W-1:0] rd_data_o
);
    logic [ADDR_W-1:0] rows_q [ROWS];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < ROWS; i++) begin
                rows_q[i] <= '0;
            end
        end else if (wr_en_i) begin
            rows_q[row_i] <= wr_data_i;
        end
    end

    assign rd_data_o = rows_q[row_i];
endmodule

// File: rtl/ram_addr_step.sv
`timescale 1ns/1ps
module ram_addr_step #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] mod_i,
    input  logic              bounded_i,
    output logic [ADDR_W-1:0] up_o,
    output logic [ADDR_W-1:0] down_o
);
    logic [ADDR_W-1:0] top;

    assign top = mod_i - ADDR_W'(1);

    always_comb begin
        if (!bounded_i) begin
            up_o   = addr_i + ADDR_W'(1);
            down_o = addr_i - ADDR_W'(1);
        end else begin
            up_o   = (addr_i >= top) ? '0 : addr_i + ADDR_W'(1);
            down_o = (addr_i == '0 || addr_i >= mod_i) ? top : addr_i - ADDR_W'(1);
        end
    end
endmodule

// File: rtl/ram_addr_unit.sv
`timescale 1ns/1ps
module ram_addr_unit
    import ram_addr_pkg::*;
#(
    parameter int ADDR_W = ram_addr_pkg::ADDR_W,
    parameter int ROWS   = ram_addr_pkg::ROWS,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        cmd_i,
    input  logic [ROW_W-1:0]  row_i,
    output logic [ADDR_W-1:0] addr_o
);
    cmd_e              cmd;
    wrap_e             state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [ADDR_W-1:0] mod_q, mod_d;
    logic [ADDR_W-1:0] up_addr, down_addr, tab_rd;
    logic              tab_we;

    assign cmd = cmd_e'(cmd_i);

    ram_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .addr_i    (addr_q),
        .mod_i     (mod_q),
        .bounded_i (state_q == WRAP_BOUNDED),
        .up_o      (up_addr),
        .down_o    (down_addr)
    );

    ram_addr_table #(.ADDR_W(ADDR_W), .ROWS(ROWS)) u_table (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (tab_we),
        .row_i     (row_i),
        .wr_data_i (addr_q),
        .rd_data_o (tab_rd)
    );

    // Wrap-mode controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WRAP_FULL:    if (cmd == CMD_SETMOD && addr_q != '0) state_d = WRAP_BOUNDED;
            WRAP_BOUNDED: if (cmd == CMD_SETMOD && addr_q == '0) state_d = WRAP_FULL;
            default:      state_d = WRAP_FULL;
        endcase
    end

    // State and data registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= WRAP_FULL;
            addr_q  <= '0;
            mod_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            mod_q   <= mod_d;
        end
    end

    // Command decode: register updates and table write
    always_comb begin
        addr_d = addr_q;
        mod_d  = mod_q;
        tab_we = 1'b0;
        unique case (cmd)
            CMD_HOLD:   addr_d = addr_q;
            CMD_CLEAR:  addr_d = '0;
            CMD_UP:     addr_d = up_addr;
            CMD_DOWN:   addr_d = down_addr;
            CMD_SETMOD: mod_d  = addr_q;
            CMD_LOAD:   addr_d = tab_rd;
            CMD_SAVE:   tab_we = 1'b1;
            CMD_RSVD:   addr_d = addr_q;
            default:    addr_d = addr_q;
        endcase
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/ram_addr_unit_chk.sv
`timescale 1ns/1ps
module ram_addr_unit_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [2:0]        cmd_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [ADDR_W-1:0] mod_q
);
    logic [ADDR_W-1:0] lim;
    assign lim = mod_q - ADDR_W'(1);

    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i == 3'd0 |=> $stable(addr_o));

    a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i == 3'd1 |=> addr_o == '0);

    a_r4_up_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 3'd2 && mod_q == '0) |=> addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1)));

    a_r5_down_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 3'd3 && mod_q == '0) |=> addr_o == ADDR_W'($past(addr_o) - ADDR_W'(1)));

    a_r6_setmod: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i == 3'd4 |=> (mod_q == $past(addr_o) && $stable(addr_o)));

    a_r7_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 3'd2 && mod_q != '0 && addr_o >= lim) |=> addr_o == '0);

    a_r7_up_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 3'd2 && mod_q != '0 && addr_o < lim) |=> addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1)));

    a_r8_down_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 3'd3 && mod_q != '0 && addr_o == '0) |=> addr_o == $past(lim));

    a_r9_save_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i == 3'd6 |=> $stable(addr_o));

    a_r11_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i == 3'd7 |=> ($stable(addr_o) && $stable(mod_q)));
endmodule

bind ram_addr_unit ram_addr_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_i),
    .addr_o (addr_o),
    .mod_q  (mod_q)
);

// File: tb/ram_addr_unit_bench.sv
`timescale 1ns/1ps
module ram_addr_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [5:0] row = 6'd0;
    logic [6:0] addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [6:0] m_addr = '0;
    logic [6:0] m_mod = '0;
    logic [6:0] m_tab [64];
    logic [6:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    ram_addr_unit u_ram_addr_unit (
        .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .row_i(row), .addr_o(addr)
    );

    task automatic check(input logic [6:0] act, input logic [6:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: applies one command and queues the address expected after the edge
    task automatic issue(input logic [2:0] c, input logic [5:0] r, input string tag);
        @(negedge clk);
        cmd = c;
        row = r;
        case (c)
            3'd1: m_addr = '0;
            3'd2: if (m_mod == 0) m_addr = m_addr + 7'd1;
                  else m_addr = (m_addr >= m_mod - 7'd1) ? 7'd0 : m_addr + 7'd1;
            3'd3: if (m_mod == 0) m_addr = m_addr - 7'd1;
                  else m_addr = (m_addr == 0 || m_addr >= m_mod) ? m_mod - 7'd1 : m_addr - 7'd1;
            3'd4: m_mod = m_addr;
            3'd5: m_addr = m_tab[r];
            3'd6: m_tab[r] = m_addr;
            default: ;
        endcase
        exp_q.push_back(m_addr);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares the design's address just after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [6:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(addr, e, t);
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 64; i++) m_tab[i] = '0;
        repeat (3) @(negedge clk);
        check(addr, 7'd0, "R1 reset");
        rst_n = 1'b1;
        check(addr, 7'd0, "R1 after release");

        issue(3'd5, 6'd10, "R1 unwritten row reads 0");
        issue(3'd0, 6'd0, "R2 hold");
        issue(3'd2, 6'd0, "R4 up");
        issue(3'd2, 6'd0, "R4 up");
        issue(3'd2, 6'd0, "R4 up");
        issue(3'd0, 6'd0, "R2 hold at 3");
        issue(3'd1, 6'd0, "R3 clear");
        issue(3'd3, 6'd0, "R5 down wraps to 127");
        issue(3'd2, 6'd0, "R4 up wraps to 0");
        for (int i = 0; i < 5; i++) issue(3'd2, 6'd0, "R4 walk to 5");
        issue(3'd4, 6'd0, "R6 set modulus keeps address");
        issue(3'd2, 6'd0, "R7 up at modulus wraps");
        for (int i = 0; i < 4; i++) issue(3'd2, 6'd0, "R7 up inside");
        issue(3'd2, 6'd0, "R7 up from M-1 wraps");
        issue(3'd3, 6'd0, "R8 down from 0 to M-1");
        issue(3'd3, 6'd0, "R8 down inside");
        issue(3'd6, 6'd63, "R9 save keeps address");
        issue(3'd1, 6'd0, "R3 clear");
        issue(3'd5, 6'd63, "R10 load saved row");
        issue(3'd7, 6'd0, "R11 reserved");
        issue(3'd2, 6'd0, "R11 modulus intact after reserved");
        issue(3'd1, 6'd0, "R3 clear");
        issue(3'd4, 6'd0, "R12 modulus zero");
        issue(3'd3, 6'd0, "R12 full-range down");

        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[2:0], lfsr[8:3], "R2 R10 mixed sequence");
        end
        repeat (3) issue(3'd0, 6'd0, "R2 final hold");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule